// File: doc/BRIEF.md
# Prescaled Up-Counter Timer Core

This block is a 32-bit timer that counts upward on an input tick, optionally slowed by a power-of-two prescaler. When the count passes its all-ones value the block raises an overflow event. It then either reloads from a load register and keeps running, or clears the count and stops itself. A compare unit raises a match event when a count step lands on a programmed value. Overflow and match leave the block as one-cycle strobes, so that separate pin-waveform and capture blocks can act on them. A capture event from such a block comes back in on an input.

Software reaches the timer through a plain 32-bit register port: a write strobe, an address and write data, with read data returned combinationally from the address. The events feed a latched status word, gated by an interrupt-enable mask, that drives a level interrupt. A separate wake-up mask turns each enabled event into a one-cycle wake pulse, whatever the interrupt enable says. Two configuration registers each carry a soft-reset bit that returns all state to zero.

Top module: `tmr_core`

## Requirements
- R1: After reset the counter, load, match, control, status and both enable masks read 0, `irq_o`, `wake_o` and both strobes are low, the identity register (offset 0x00) reads 0x21 and the trigger register (offset 0x30) reads 0xFFFFFFFF.
- R2: Control register (offset 0x24) bit 0 starts the timer. With the prescaler off, the counter (offset 0x28) rises by one for every clock cycle in which `tick_i` is high. With bit 0 clear the counter holds.
- R3: With control bit 5 set, the counter advances once every 2^(d+1) ticks, where d is control bits 4:2. The prescaler restarts from zero on any control write.
- R4: A count step taken from 0xFFFFFFFF with control bit 1 (auto-reload) set loads the value of the load register (offset 0x2C). `ovf_stb_o` is high for the one cycle that follows that step.
- R5: The same overflow with auto-reload clear sets the counter to 0 and clears control bit 0, so counting stops.
- R6: Any write to the trigger register copies the load register into the counter.
- R7: With control bit 6 (compare enable) set, a count step whose result equals the match register (offset 0x38) gives a one-cycle `mat_stb_o`. A match value below the running count does not fire before the wrap, and nothing fires with bit 6 clear.
- R8: Status (offset 0x18) bit 0 is match, bit 1 is overflow and bit 2 is the capture input `cap_evt_i`. A bit latches only when the same bit of the interrupt-enable register (offset 0x1C) is set. `irq_o` is high while any status bit is set, and writing 1 to a status bit clears it.
- R9: `wake_o` pulses for one cycle after any event whose bit is set in the wake-up-enable register (offset 0x20), regardless of the interrupt enable.
- R10: Writing a value with bit 1 set to offset 0x10 or to offset 0x40 clears every register, the counter and the status back to zero.
- R11: The control register reads back its written bits 14:0, and bits 14:7 (pin direction, second-capture, toggle, trigger mode, capture mode, idle level) appear on `pin_cfg_o` for the neighbour blocks.
- R12: Offsets other than those listed read as 0, and writes to them, or to the identity register, change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count tick enable, one tick per high cycle |
| cap_evt_i | input | 1 | One-cycle capture event from the capture block |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt, high while any status bit is set |
| wake_o | output | 1 | One-cycle wake-up pulse |
| ovf_stb_o | output | 1 | One-cycle overflow strobe |
| mat_stb_o | output | 1 | One-cycle match strobe |
| pin_cfg_o | output | 8 | Control bits 14:7 for the pin and capture blocks |

## Verification
On every cycle the assertions check several relations. A count step moves the counter up by one, or to the load value or zero on overflow. An overflow without reload stops the timer. A step happens only on a tick while the timer runs. A status bit never rises without its enable, and a wake pulse always has an enabled event behind it. Only the bench's scenarios can show the true division ratio for each prescaler setting, the exact strobe counts around the wrap, and match values below the count staying silent. The same holds for register readback, the two soft-reset paths, and writes to unknown offsets leaving state untouched.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PTV_W = 3;
  localparam int EV_W  = 3;
  localparam int EV_MAT = 0;
  localparam int EV_OVF = 1;
  localparam int EV_CAP = 2;

  localparam logic [7:0] OFF_IDENT = 8'h00;
  localparam logic [7:0] OFF_CFG   = 8'h10;
  localparam logic [7:0] OFF_STAT  = 8'h18;
  localparam logic [7:0] OFF_IEN   = 8'h1C;
  localparam logic [7:0] OFF_WEN   = 8'h20;
  localparam logic [7:0] OFF_CTRL  = 8'h24;
  localparam logic [7:0] OFF_CNT   = 8'h28;
  localparam logic [7:0] OFF_LOAD  = 8'h2C;
  localparam logic [7:0] OFF_TRIG  = 8'h30;
  localparam logic [7:0] OFF_MATCH = 8'h38;
  localparam logic [7:0] OFF_IFC   = 8'h40;
  localparam logic [7:0] IDENT_VAL = 8'h21;

  typedef struct packed {
    logic             pin_dir;
    logic             cap2_sel;
    logic             toggle;
    logic [1:0]       trig_mode;
    logic [1:0]       cap_mode;
    logic             idle_lvl;
    logic             cmp_en;
    logic             pre_en;
    logic [PTV_W-1:0] ptv;
    logic             reload;
    logic             run;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick_i,
  input  logic             run,
  input  logic             pre_en,
  input  logic [DIV_W-1:0] ptv,
  output logic             step
);
  localparam int PC_W = 1 << DIV_W;

  logic [PC_W-1:0] pc_q, pc_d, last;
  logic            pc_en;

  always_comb begin
    last  = {PC_W{1'b1}} >> (DIV_W'(PC_W - 1) - ptv);
    step  = run & tick_i & (~pre_en | (pc_q == last));
    pc_en = clr | ~run | ~pre_en | tick_i;
    if (clr || !run || !pre_en) pc_d = '0;
    else if (pc_q == last)      pc_d = '0;
    else                        pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (tick_i && run)); // R3
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             reload_en,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] match_val,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             force_ld,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_evt,
  output logic             mat_evt,
  output logic             stop_req
);
  logic [CNT_W-1:0] cnt_d, step_val;
  logic             at_max, override, cnt_en;

  always_comb begin
    at_max   = &cnt_q;
    override = clr | wr_cnt | force_ld;
    if (at_max) step_val = reload_en ? load_val : '0;
    else        step_val = cnt_q + 1'b1;
    ovf_evt  = step & at_max & ~override;
    mat_evt  = step & cmp_en & (step_val == match_val) & ~override;
    stop_req = ovf_evt & ~reload_en;
    cnt_en   = override | step;
    if (clr)           cnt_d = '0;
    else if (wr_cnt)   cnt_d = wr_data;
    else if (force_ld) cnt_d = load_val;
    else               cnt_d = step_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !override && !at_max) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !override && at_max && reload_en) |=> (cnt_q == $past(load_val))); // R4
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !override && at_max && !reload_en) |=> (cnt_q == '0)); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !override) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int EVN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [EVN-1:0] evt,
  input  logic [EVN-1:0] ien,
  input  logic [EVN-1:0] wen,
  input  logic           ack_wr,
  input  logic [EVN-1:0] ack_mask,
  output logic [EVN-1:0] status_q,
  output logic           irq_o,
  output logic           wake_o
);
  logic [EVN-1:0] status_d, ack_v;
  logic           wake_d;

  always_comb begin
    ack_v    = ack_wr ? ack_mask : '0;
    status_d = clr ? '0 : ((status_q & ~ack_v) | (evt & ien));
    wake_d   = ~clr & (|(evt & wen));
    irq_o    = |status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      wake_o   <= 1'b0;
    end else begin
      status_q <= status_d;
      wake_o   <= wake_d;
    end
  end

  AST_STAT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(ien)) == '0)); // R8
  AST_WAKE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(|(evt & wen))); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && (&ack_mask) && evt == '0) |=> !irq_o); // R8
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              cap_evt_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic              ovf_stb_o,
  output logic              mat_stb_o,
  output logic [7:0]        pin_cfg_o
);
  localparam int PAD_CTRL = CNT_W - CTRL_W;
  localparam int PAD_EV   = CNT_W - EV_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // register decode
  logic hit_ctrl, hit_cnt, hit_load, hit_trig, hit_match;
  logic hit_stat, hit_ien, hit_wen, srst;
  always_comb begin
    hit_ctrl  = reg_wr_i & (reg_addr_i == ADDR_W'(OFF_CTRL));
    hit_cnt   = reg_wr_i & (reg_addr_i == ADDR_W'(OFF_CNT));
    hit_load  = reg_wr_i & (reg_addr_i == ADDR_W'(OFF_LOAD));
    hit_trig  = reg_wr_i & (reg_addr_i == ADDR_W'(OFF_TRIG));
    hit_match = reg_wr_i & (reg_addr_i == ADDR_W'(OFF_MATCH));
    hit_stat  = reg_wr_i & (reg_addr_i == ADDR_W'(OFF_STAT));
    hit_ien   = reg_wr_i & (reg_addr_i == ADDR_W'(OFF_IEN));
    hit_wen   = reg_wr_i & (reg_addr_i == ADDR_W'(OFF_WEN));
    srst      = reg_wr_i & reg_wdata_i[1] &
                ((reg_addr_i == ADDR_W'(OFF_CFG)) | (reg_addr_i == ADDR_W'(OFF_IFC)));
  end

  // configuration registers
  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-1:0] load_q, load_d, match_q, match_d;
  logic [EV_W-1:0]  ien_q, ien_d, wen_q, wen_d;
  logic             ctrl_en, load_en, match_en, ien_en, wen_en;
  logic             stop_req;

  always_comb begin
    ctrl_en  = srst | hit_ctrl | stop_req;
    load_en  = srst | hit_load;
    match_en = srst | hit_match;
    ien_en   = srst | hit_ien;
    wen_en   = srst | hit_wen;
    ctrl_d   = ctrl_q;
    if (srst)          ctrl_d = '0;
    else if (hit_ctrl) ctrl_d = tmr_ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
    else if (stop_req) ctrl_d.run = 1'b0;
    load_d   = srst ? '0 : reg_wdata_i;
    match_d  = srst ? '0 : reg_wdata_i;
    ien_d    = srst ? '0 : reg_wdata_i[EV_W-1:0];
    wen_d    = srst ? '0 : reg_wdata_i[EV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
      ien_q   <= '0;
      wen_q   <= '0;
    end else begin
      if (ctrl_en)  ctrl_q  <= ctrl_d;
      if (load_en)  load_q  <= load_d;
      if (match_en) match_q <= match_d;
      if (ien_en)   ien_q   <= ien_d;
      if (wen_en)   wen_q   <= wen_d;
    end
  end

  // datapath
  logic             step, ovf_evt, mat_evt;
  logic [CNT_W-1:0] cnt_q;
  logic [EV_W-1:0]  evt, status_q;

  tmr_prescaler #(.DIV_W(PTV_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_ni),
    .clr    (srst | hit_ctrl),
    .tick_i (tick_i),
    .run    (ctrl_q.run),
    .pre_en (ctrl_q.pre_en),
    .ptv    (ctrl_q.ptv),
    .step   (step)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_ni),
    .clr       (srst),
    .step      (step),
    .reload_en (ctrl_q.reload),
    .cmp_en    (ctrl_q.cmp_en),
    .load_val  (load_q),
    .match_val (match_q),
    .wr_cnt    (hit_cnt),
    .wr_data   (reg_wdata_i),
    .force_ld  (hit_trig),
    .cnt_q     (cnt_q),
    .ovf_evt   (ovf_evt),
    .mat_evt   (mat_evt),
    .stop_req  (stop_req)
  );

  always_comb begin
    evt         = '0;
    evt[EV_MAT] = mat_evt;
    evt[EV_OVF] = ovf_evt;
    evt[EV_CAP] = cap_evt_i & ~srst;
  end

  tmr_irq #(.EVN(EV_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_ni),
    .clr      (srst),
    .evt      (evt),
    .ien      (ien_q),
    .wen      (wen_q),
    .ack_wr   (hit_stat),
    .ack_mask (reg_wdata_i[EV_W-1:0]),
    .status_q (status_q),
    .irq_o    (irq_o),
    .wake_o   (wake_o)
  );

  // event strobes
  logic ovf_stb_d, mat_stb_d;
  always_comb begin
    ovf_stb_d = ovf_evt;
    mat_stb_d = mat_evt;
  end
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_stb_o <= 1'b0;
      mat_stb_o <= 1'b0;
    end else begin
      ovf_stb_o <= ovf_stb_d;
      mat_stb_o <= mat_stb_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    if      (reg_addr_i == ADDR_W'(OFF_IDENT)) reg_rdata_o = CNT_W'(IDENT_VAL);
    else if (reg_addr_i == ADDR_W'(OFF_STAT))  reg_rdata_o = {{PAD_EV{1'b0}}, status_q};
    else if (reg_addr_i == ADDR_W'(OFF_IEN))   reg_rdata_o = {{PAD_EV{1'b0}}, ien_q};
    else if (reg_addr_i == ADDR_W'(OFF_WEN))   reg_rdata_o = {{PAD_EV{1'b0}}, wen_q};
    else if (reg_addr_i == ADDR_W'(OFF_CTRL))  reg_rdata_o = {{PAD_CTRL{1'b0}}, ctrl_q};
    else if (reg_addr_i == ADDR_W'(OFF_CNT))   reg_rdata_o = cnt_q;
    else if (reg_addr_i == ADDR_W'(OFF_LOAD))  reg_rdata_o = load_q;
    else if (reg_addr_i == ADDR_W'(OFF_TRIG))  reg_rdata_o = '1;
    else if (reg_addr_i == ADDR_W'(OFF_MATCH)) reg_rdata_o = match_q;
  end

  assign pin_cfg_o = {ctrl_q.pin_dir, ctrl_q.cap2_sel, ctrl_q.toggle,
                      ctrl_q.trig_mode, ctrl_q.cap_mode, ctrl_q.idle_lvl};

  AST_STOP_ON_OVF: assert property (@(posedge clk) disable iff (!rst_ni)
    (stop_req && !hit_ctrl && !srst) |=> !ctrl_q.run); // R5
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
    srst |=> (cnt_q == '0 && ctrl_q == '0 && status_q == '0 && !irq_o)); // R10
  AST_STB_FROM_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (ovf_stb_o || mat_stb_o) |-> $past(step)); // R4
endmodule

// File: tb/sim_tmr_core.sv
module sim_tmr_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        cap_evt_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = 8'h00;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, wake_o, ovf_stb_o, mat_stb_o;
  logic [7:0]  pin_cfg_o;

  int errors = 0;
  int checks = 0;
  int n_ovf = 0, n_mat = 0, n_wake = 0;

  always #2.5 clk = ~clk;

  tmr_core u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cap_evt_i(cap_evt_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .wake_o(wake_o),
    .ovf_stb_o(ovf_stb_o), .mat_stb_o(mat_stb_o), .pin_cfg_o(pin_cfg_o)
  );

  always @(negedge clk) begin
    n_ovf  += int'(ovf_stb_o);
    n_mat  += int'(mat_stb_o);
    n_wake += int'(wake_o);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr_i = a;
    #1 v = reg_rdata_o;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic clr_counts();
    @(negedge clk);
    #1 n_ovf = 0; n_mat = 0; n_wake = 0;
  endtask

  task automatic soft_reset();
    wr(8'h10, 32'h2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h28, v); chk("R1 counter", v, 0);
    rd(8'h24, v); chk("R1 control", v, 0);
    rd(8'h18, v); chk("R1 status", v, 0);
    rd(8'h00, v); chk("R1 identity", v, 32'h21);
    rd(8'h30, v); chk("R1 trigger read", v, 32'hFFFF_FFFF);
    chk("R1 outputs", {28'd0, irq_o, wake_o, ovf_stb_o, mat_stb_o}, 0);

    // R2 plain counting and hold
    wr(8'h28, 32'd100);
    wr(8'h24, 32'h1);
    run_ticks(37);
    rd(8'h28, v); chk("R2 count by ticks", v, 32'd137);
    wr(8'h24, 32'h0);
    run_ticks(20);
    rd(8'h28, v); chk("R2 hold when stopped", v, 32'd137);

    // R3 prescaler sweep over every divide setting
    for (int d = 0; d < 8; d++) begin
      int div;
      div = 1 << (d + 1);
      wr(8'h28, 32'd0);
      wr(8'h24, 32'h21 | (d << 2));
      run_ticks(3 * div + div - 1);
      wr(8'h24, 32'h0);
      rd(8'h28, v); chk($sformatf("R3 prescale d=%0d", d), v, 32'd3);
    end

    // R4 / R5 overflow sweep with and without reload
    wr(8'h2C, 32'h100);
    for (int ar = 0; ar < 2; ar++) begin
      for (int d = 1; d <= 6; d++) begin
        wr(8'h28, 32'hFFFF_FFFF - 32'(d - 1));
        wr(8'h24, 32'h1 | (ar << 1));
        clr_counts();
        run_ticks(d + 2);
        rd(8'h28, v);
        if (ar == 1) begin
          chk($sformatf("R4 reload d=%0d", d), v, 32'h102);
          chk("R4 one overflow strobe", 32'(n_ovf), 1);
        end else begin
          chk($sformatf("R5 cleared d=%0d", d), v, 0);
          rd(8'h24, v); chk("R5 start cleared", v & 32'h1, 0);
          chk("R5 one overflow strobe", 32'(n_ovf), 1);
        end
      end
    end
    wr(8'h24, 32'h0);

    // R6 trigger write reloads
    wr(8'h2C, 32'hABCD_0123);
    wr(8'h28, 32'h5);
    wr(8'h30, 32'h0);
    rd(8'h28, v); chk("R6 trigger reload", v, 32'hABCD_0123);

    // R7 match: above, below, disabled
    wr(8'h38, 32'd10);
    wr(8'h28, 32'd5);
    wr(8'h24, 32'h41);
    clr_counts();
    run_ticks(10);
    chk("R7 match fires once", 32'(n_mat), 1);
    wr(8'h24, 32'h0);
    wr(8'h38, 32'd3);
    wr(8'h28, 32'd5);
    wr(8'h24, 32'h41);
    clr_counts();
    run_ticks(10);
    chk("R7 match below count silent", 32'(n_mat), 0);
    wr(8'h24, 32'h0);
    wr(8'h38, 32'd12);
    wr(8'h28, 32'd5);
    wr(8'h24, 32'h01);
    clr_counts();
    run_ticks(10);
    chk("R7 compare disabled silent", 32'(n_mat), 0);
    wr(8'h24, 32'h0);

    // R8 masked status, irq and write-one-to-clear
    wr(8'h1C, 32'h7);
    wr(8'h20, 32'h0);
    wr(8'h38, 32'd2);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h2C, 32'd0);
    wr(8'h24, 32'h43);
    run_ticks(3);
    wr(8'h24, 32'h0);
    rd(8'h18, v); chk("R8 match+overflow status", v, 32'h3);
    chk("R8 irq high", 32'(irq_o), 1);
    wr(8'h18, 32'h2);
    rd(8'h18, v); chk("R8 clear overflow only", v, 32'h1);
    wr(8'h18, 32'h1);
    rd(8'h18, v); chk("R8 all cleared", v, 0);
    chk("R8 irq low", 32'(irq_o), 0);
    @(negedge clk) cap_evt_i = 1'b1;
    @(negedge clk) cap_evt_i = 1'b0;
    rd(8'h18, v); chk("R8 capture bit", v, 32'h4);
    wr(8'h18, 32'h4);

    // R9 wake independent of interrupt enable
    wr(8'h1C, 32'h0);
    wr(8'h20, 32'h2);
    wr(8'h28, 32'hFFFF_FFFE);
    wr(8'h24, 32'h3);
    clr_counts();
    run_ticks(4);
    wr(8'h24, 32'h0);
    chk("R9 one wake pulse", 32'(n_wake), 1);
    rd(8'h18, v); chk("R9 masked status stays 0", v, 0);
    chk("R9 irq stays low", 32'(irq_o), 0);

    // R11 control readback and pin configuration
    wr(8'h24, 32'hFFFF_7F80);
    rd(8'h24, v); chk("R11 control readback", v, 32'h7F80);
    chk("R11 pin_cfg_o", 32'(pin_cfg_o), 32'hFF);
    wr(8'h24, 32'h0);

    // R12 unknown offsets and read-only identity
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h00, 32'h1234_5678);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R12 unknown reads 0", v, 0);
    rd(8'h3C, v); chk("R12 unknown reads 0 b", v, 0);
    rd(8'h00, v); chk("R12 identity unchanged", v, 32'h21);
    rd(8'h2C, v); chk("R12 load unchanged", v, 0);

    // R10 soft reset by both paths
    wr(8'h2C, 32'h55);
    wr(8'h28, 32'h77);
    wr(8'h1C, 32'h7);
    soft_reset();
    rd(8'h28, v); chk("R10 cfg reset counter", v, 0);
    rd(8'h2C, v); chk("R10 cfg reset load", v, 0);
    rd(8'h1C, v); chk("R10 cfg reset ien", v, 0);
    wr(8'h38, 32'h99);
    wr(8'h24, 32'h41);
    wr(8'h40, 32'h2);
    rd(8'h38, v); chk("R10 ifc reset match", v, 0);
    rd(8'h24, v); chk("R10 ifc reset control", v, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule